// File: doc/BRIEF.md
# Serial-Clocked SAR Conversion Controller

This block is the digital control core of a 12-bit successive-approximation converter. It has no clock of its own. The host's serial clock paces everything the block does. An active-low chip select opens a frame of sixteen serial clocks. Within one frame the block does three things:

- It shifts an 8-bit control byte in from the serial data input.
- It runs a bit-by-bit binary search against a single comparator input.
- It returns the resulting straight-binary code on the serial data output.

The analog side is not part of the block. The track/hold, the charge-redistribution DAC and the reference stay outside. The DAC sees only the 12-bit trial code the block drives, and the comparator answers with one bit: 1 when the sampled input is at or above the trial code.

The control byte picks single-channel or two-channel operation, and the input channel in two-channel operation. A host that never drives the data input (it holds it low) gets read-only single-channel conversions with no configuration change. A new byte is applied only when its frame runs to completion, and it governs the following frame. A frame cut short by chip select rising releases the output and leaves the configuration alone. The output is driven only while chip select is low. High impedance is represented by `dout_oe` going low.

Top module: `sarc_core`

## Requirements
- R1: A frame spans 16 rising edges of `sclk` after `cs_n` falls. After the falling edge that follows rising edge k, `dout` holds 0 for k = 1 to 4 and result bit 16−k for k = 5 to 16. The host therefore reads 4 zeros and then the 12-bit result, MSB first, on rising edges.
- R2: For an analog input given as an integer code N in 0..4095, with `cmp` = (N ≥ `trial_code`), the frame's result equals N exactly, including 0 and 4095.
- R3: After rising edge 4 of a frame, `trial_code` is 0x800. After rising edge 5 it is 0x400 OR'd with 0x800 if the comparator answered 1 at edge 5.
- R4: The control byte is taken from `din` on rising edges 1 to 8, MSB first. Bit 7 is write enable, bit 6 selects two-channel mode, bit 5 is the channel select, and bits 4..0 have no effect.
- R5: The control register is updated only at rising edge 16 of a frame, and only if bit 7 of the byte is 1. The conversion in that same frame still uses the previous setting.
- R6: A frame with `din` held low throughout changes neither `dual_mode` nor `chan`.
- R7: When two-channel mode is off, `chan` is 0 whatever the channel select bit holds.
- R8: If `cs_n` rises before rising edge 16, `dout_oe` drops at once, the control register keeps its value, and the next full frame converts normally.
- R9: `dout_oe` is low whenever `cs_n` is high. After reset, `dual_mode`, `chan` and `trial_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Host serial clock; paces the transfer and the conversion |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial control byte input, sampled on rising edges |
| cmp | input | 1 | Comparator answer: 1 when input ≥ trial code |
| dout | output | 1 | Serial result output, updated on falling edges |
| dout_oe | output | 1 | Output enable for `dout`; low means high impedance |
| trial_code | output | 12 | Code applied to the DAC during the search |
| track | output | 1 | High while the front end should track the input |
| dual_mode | output | 1 | Active setting: two-channel operation |
| chan | output | 1 | Active analog input channel |

## Verification
The hardest case to reach is a frame that loses chip select after a complete control byte with write enable set has already been shifted in, but before the sixteenth edge. Only the missing commit keeps that byte out of the register. The bench builds this case by running a frame of ten clocks that carries a valid write, then checks `chan` and `dual_mode` and runs a full frame after it. It also tests the next-frame rule: it writes a channel change while the two channel inputs hold distinct codes, and the scoreboard expects the old channel's code in the writing frame and the new channel's code in the one after.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
  localparam int RES_W      = 12;
  localparam int CFG_W      = 8;
  localparam int ACQ_CLKS   = 4;
  localparam int FRAME_CLKS = ACQ_CLKS + RES_W;
  localparam int CNT_W      = $clog2(FRAME_CLKS + 1);

  // control byte field positions (shifted in MSB first)
  localparam int CFG_WE_BIT   = 7;
  localparam int CFG_DUAL_BIT = 6;
  localparam int CFG_SEL_BIT  = 5;

  typedef struct packed {
    logic dual;
    logic sel;
  } sarc_cfg_t;
endpackage

// File: rtl/sarc_frame_ctr.sv
module sarc_frame_ctr #(
  parameter int FRAME = sarc_pkg::FRAME_CLKS,
  parameter int ACQ   = sarc_pkg::ACQ_CLKS,
  parameter int CFGW  = sarc_pkg::CFG_W,
  parameter int CW    = sarc_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  output logic [CW-1:0] cnt,
  output logic          shift_en,
  output logic          last_edge,
  output logic          track
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (cs_n)                cnt <= '0;
    else if (cnt != CW'(FRAME))   cnt <= cnt + 1'b1;
  end

  assign shift_en  = !cs_n && (cnt < CW'(CFGW));
  assign last_edge = !cs_n && (cnt == CW'(FRAME - 1));
  assign track     = (cnt < CW'(ACQ));

  // R1: a deselected frame always restarts from edge zero
  a_r1_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cnt == '0));
endmodule

// File: rtl/sarc_cfg_reg.sv
module sarc_cfg_reg
  import sarc_pkg::*;
#(
  parameter int CFGW = sarc_pkg::CFG_W
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      shift_en,
  input  logic      din,
  input  logic      commit,
  output sarc_cfg_t cfg,
  output logic      chan
);
  logic [CFGW-1:0] shreg;
  sarc_cfg_t       cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shreg <= '0;
    else if (shift_en) shreg <= {shreg[CFGW-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (commit && shreg[CFG_WE_BIT]) begin
      cfg_q.dual <= shreg[CFG_DUAL_BIT];
      cfg_q.sel  <= shreg[CFG_SEL_BIT];
    end
  end

  assign cfg  = cfg_q;
  assign chan = cfg_q.dual & cfg_q.sel;

  // R5: the register moves only on a completed frame
  a_r5_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cfg_q));
  // R6: a byte without write enable leaves the setting alone
  a_r6_we_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !shreg[CFG_WE_BIT]) |=> $stable(cfg_q));
endmodule

// File: rtl/sarc_search.sv
module sarc_search #(
  parameter int RES   = sarc_pkg::RES_W,
  parameter int ACQ   = sarc_pkg::ACQ_CLKS,
  parameter int CW    = sarc_pkg::CNT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic [CW-1:0]  cnt,
  input  logic           cmp,
  output logic [RES-1:0] trial,
  output logic [RES-1:0] result
);
  logic [RES-1:0] sar_q;
  logic [RES-1:0] step_mask;

  always_comb begin
    for (int i = 0; i < RES; i++)
      step_mask[i] = !cs_n && (cnt == CW'(ACQ + RES - 1 - i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sar_q <= '0;
    else if (cs_n)  sar_q <= '0;
    else begin
      for (int i = 0; i < RES; i++)
        if (step_mask[i]) sar_q[i] <= cmp;
    end
  end

  assign trial  = sar_q | step_mask;
  assign result = sar_q;

  // R3: the search opens at mid scale
  a_r3_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cnt == CW'(ACQ)) |-> (trial == {1'b1, {(RES-1){1'b0}}}));
endmodule

// File: rtl/sarc_txd.sv
module sarc_txd #(
  parameter int RES   = sarc_pkg::RES_W,
  parameter int ACQ   = sarc_pkg::ACQ_CLKS,
  parameter int FRAME = sarc_pkg::FRAME_CLKS,
  parameter int CW    = sarc_pkg::CNT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic [CW-1:0]  cnt,
  input  logic [RES-1:0] result,
  output logic           dout
);
  logic nxt;

  always_comb begin
    nxt = 1'b0;
    for (int i = 0; i < RES; i++)
      if (!cs_n && cnt == CW'(FRAME - i)) nxt = result[i];
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) dout <= 1'b0;
    else        dout <= nxt;
  end

  // R1: the acquisition slots shift out zeros
  a_r1_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && cnt <= CW'(ACQ)) |-> !dout);
endmodule

// File: rtl/sarc_core.sv
module sarc_core
  import sarc_pkg::*;
(
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             din,
  input  logic             cmp,
  output logic             dout,
  output logic             dout_oe,
  output logic [RES_W-1:0] trial_code,
  output logic             track,
  output logic             dual_mode,
  output logic             chan
);
  logic [CNT_W-1:0] cnt;
  logic             shift_en, last_edge;
  logic [RES_W-1:0] result;
  sarc_cfg_t        cfg;

  sarc_frame_ctr u_ctr (
    .clk(sclk), .rst_n(rst_n), .cs_n(cs_n), .cnt(cnt),
    .shift_en(shift_en), .last_edge(last_edge), .track(track)
  );

  sarc_cfg_reg u_cfg (
    .clk(sclk), .rst_n(rst_n), .shift_en(shift_en), .din(din),
    .commit(last_edge), .cfg(cfg), .chan(chan)
  );

  sarc_search u_sar (
    .clk(sclk), .rst_n(rst_n), .cs_n(cs_n), .cnt(cnt), .cmp(cmp),
    .trial(trial_code), .result(result)
  );

  sarc_txd u_txd (
    .clk(sclk), .rst_n(rst_n), .cs_n(cs_n), .cnt(cnt),
    .result(result), .dout(dout)
  );

  assign dout_oe   = !cs_n;
  assign dual_mode = cfg.dual;

  // R5: the active channel cannot move inside a running frame
  a_r5_chan_frame_stable: assert property (@(posedge sclk) disable iff (!rst_n)
    (cnt != '0 && cnt < CNT_W'(FRAME_CLKS)) |-> $stable(chan));
endmodule

// File: tb/sim_sarc_core.sv
module sim_sarc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        din = 1'b0;
  logic        cmp;
  logic        dout, dout_oe, track, dual_mode, chan;
  logic [11:0] trial_code;
  logic [11:0] ain0 = '0, ain1 = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];
  logic m_dual = 0, m_sel = 0;

  always #5 clk = ~clk;

  // comparator and channel mux model of the analog front end
  assign cmp = ((chan ? ain1 : ain0) >= trial_code);

  sarc_core u0 (
    .sclk(clk), .rst_n(rst_n), .cs_n(cs_n), .din(din), .cmp(cmp),
    .dout(dout), .dout_oe(dout_oe), .trial_code(trial_code), .track(track),
    .dual_mode(dual_mode), .chan(chan)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: assembles each 16-bit frame and compares with the scoreboard
  int          mcnt = 0;
  logic [15:0] word = '0;
  always @(negedge clk) begin
    #1;
    if (cs_n) begin
      mcnt = 0;
      word = '0;
    end else begin
      word = {word[14:0], dout};
      mcnt++;
      if (mcnt == 16) begin
        if (exp_q.size() == 0) chk("R1 unexpected frame", 32'(word), 32'hFFFF);
        else chk("R1/R2 frame word", 32'(word), 32'(exp_q.pop_front()));
      end
    end
  end

  // driver: one frame with a control byte, nclk clocks long
  task automatic run_frame(input logic [7:0] cfg, input int nclk,
                           input logic [11:0] a0, input logic [11:0] a1);
    logic [11:0] code;
    ain0 = a0;
    ain1 = a1;
    code = (m_dual && m_sel) ? a1 : a0;
    if (nclk == 16) exp_q.push_back({4'b0, code});
    cs_n = 1'b0;
    for (int k = 1; k <= nclk; k++) begin
      din = (k <= 8) ? cfg[8-k] : 1'b0;
      @(posedge clk);
      @(negedge clk);
      #2;
      if (k == 4) chk("R3 first trial", 32'(trial_code), 32'h800);
      if (k == 5) chk("R3 second trial", 32'(trial_code),
                      32'((code >= 12'h800 ? 12'h800 : 12'h000) | 12'h400));
    end
    cs_n = 1'b1;
    din = 1'b0;
    #1;
    chk(nclk == 16 ? "R9 release after frame" : "R8 release on abort", 32'(dout_oe), 0);
    if (nclk == 16 && cfg[7]) begin
      m_dual = cfg[6];
      m_sel  = cfg[5];
    end
    @(posedge clk);
    @(negedge clk);
    #2;
    chk("R4/R5/R6/R7/R8 dual_mode", 32'(dual_mode), 32'(m_dual));
    chk("R4/R5/R6/R7/R8 chan", 32'(chan), 32'(m_dual & m_sel));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] lfsr;
    repeat (3) @(negedge clk);
    #2;
    chk("R9 reset oe", 32'(dout_oe), 0);
    chk("R9 reset dual", 32'(dual_mode), 0);
    chk("R9 reset chan", 32'(chan), 0);
    chk("R9 reset trial", 32'(trial_code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #2;

    // R2: read-only frames, end codes and mid-scale neighbours
    run_frame(8'h00, 16, 12'd0,    12'd999);
    run_frame(8'h00, 16, 12'd4095, 12'd1);
    run_frame(8'h00, 16, 12'd2048, 12'd7);
    run_frame(8'h00, 16, 12'd2047, 12'd7);
    run_frame(8'h00, 16, 12'd1,    12'd4000);
    run_frame(8'h00, 16, 12'd1365, 12'd2730);

    // R5: write two-channel + channel 1; this frame still converts channel 0
    run_frame(8'hE0, 16, 12'd100, 12'd3000);
    // R6: read-only frame keeps channel 1 and converts ain1
    run_frame(8'h00, 16, 12'd100, 12'd3000);
    // R5: byte without write enable has no effect
    run_frame(8'h40, 16, 12'd5, 12'd3001);
    // R4: reserved bits set, channel select cleared
    run_frame(8'hDF, 16, 12'd6, 12'd3002);
    // R8: valid write aborted after ten clocks
    run_frame(8'hE0, 10, 12'd6, 12'd3003);
    run_frame(8'h00, 16, 12'd77, 12'd3004);
    // R7: single-channel with select bit set gives channel 0
    run_frame(8'hA0, 16, 12'd9, 12'd500);
    run_frame(8'h00, 16, 12'd9, 12'd500);

    // R2: pseudo-random codes
    lfsr = 12'hACE;
    for (int n = 0; n < 8; n++) begin
      lfsr = {lfsr[10:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]};
      run_frame(8'h00, 16, lfsr, ~lfsr);
    end

    repeat (4) @(negedge clk);
    chk("R1 all frames delivered", 32'(exp_q.size()), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule